// File: doc/BRIEF.md
# Streaming Pooling Border and Padding Controller

This block sits on a raster-ordered stream of feature-map activations in which every activation word travels bit-serially, least significant bit first, over `DW` consecutive cycles. A one-cycle word strobe marks the first bit of each word. A frame-start flag raised together with a strobe marks the first word of a map. From those strobes alone the block keeps the column and row of the current word. It decides whether the word is an output of a pooling stage with the configured window and stride, and under which border rule. It needs no line buffer and no memory array.

Each word comes out exactly one word time later, with a valid flag held over all of its bits. Positions that fall off the stride grid, or that the border rule excludes, come out with the valid flag low and their bits untouched. In padding mode, grid positions whose window overhangs the top or left map edge come out as valid words whose bits are all zero. The block is meant to follow a bit-serial max or sum unit and to clean up its output stream before the next layer.

Top module: `pool_border_ctrl`

## Requirements
- R1: After reset, `out_valid`, `out_first` and `out_bit` are 0. Every word that enters before the first strobe carrying `in_frame` leaves with `out_valid` low.
- R2: A strobe without `in_frame` moves the column up by one. When the column was `cfg_width-1`, the column goes to 0 and the row moves up by one. When the row was `cfg_height-1`, the row goes back to 0, so a stream that runs on past a frame starts the map again at row 0.
- R3: A strobe with `in_frame` high places that word at row 0, column 0, whatever position the previous word held.
- R4: With stride S = `cfg_stride` (S of 1 or more), a word is kept only if its row and column, less the mode's grid offset, are both at least zero and both multiples of S.
- R5: Mode `cfg_mode` = 0 (edge-exclusive) uses the grid offset K-1, where K = `cfg_win` (K of 1 or more). Words with a row or column below K-1 therefore never leave valid.
- R6: Mode 1 (edge-inclusive) uses grid offset 0. Kept words whose window overhangs the edge leave valid, and their bits are the input bits.
- R7: Modes 2 and 3 (zero-padding) use grid offset 0. A kept word with a row or column below K-1 leaves with `out_valid` high and all `DW` bits 0. Every other kept word passes its bits unchanged.
- R8: Bit i of a word leaves on `out_bit` exactly `DW` cycles after it entered. `out_first` is high only with bit 0 of a word. `out_valid` stays at one value across all `DW` bits of a word and is low when no word is leaving.
- R9: A word that is not kept leaves with `out_valid` low, and its bits are the input bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | CW | Map width in words per row |
| cfg_height | input | CW | Map height in rows |
| cfg_stride | input | SW | Subsampling stride |
| cfg_win | input | SW | Pooling window size |
| cfg_mode | input | 2 | Border rule: 0 edge-exclusive, 1 edge-inclusive, 2 or 3 zero-padding |
| in_bit | input | 1 | Serial activation bit, LSB first |
| in_first | input | 1 | Word strobe, high with bit 0 of each word; strobes at least DW cycles apart |
| in_frame | input | 1 | Frame start, sampled with `in_first` |
| out_bit | output | 1 | Serial output bit |
| out_first | output | 1 | High with bit 0 of each output word |
| out_valid | output | 1 | Output word is a valid activation |

## Verification
Two functions collide when a strobe carries a frame restart at a point where the coordinate counters would otherwise wrap or advance mid-row. The bench provokes this by cutting a frame short and restarting it, and judges the result by whether the words that follow match the grid seen from a fresh origin. A second collision happens on back-to-back words, where the output stage latches the next word's decision on the same edge that releases the previous word's last bit. Full frames are streamed with no gaps so that every word's valid level and all of its bits are compared against the scoreboard.

// File: rtl/pool_border_pkg.sv
package pool_border_pkg;

  typedef enum logic [1:0] {
    BM_EDGE_EXCL = 2'd0,
    BM_EDGE_INCL = 2'd1,
    BM_ZERO_PAD  = 2'd2,
    BM_ZERO_PAD2 = 2'd3
  } border_mode_e;

  // One serial lane sample carried down the word delay line
  typedef struct packed {
    logic act;    // inside a word
    logic first;  // bit 0 of a word
    logic dat;    // data bit
  } lane_t;

endpackage

// File: rtl/pool_axis_tracker.sv
module pool_axis_tracker #(
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  input  logic [CW-1:0] last,
  input  logic [CW-1:0] off,
  input  logic [SW-1:0] stride,
  output logic [CW-1:0] pos,
  output logic          at_last,
  output logic          aligned
);

  logic [SW-1:0] phase;
  logic [SW-1:0] ph_last;
  logic [CW-1:0] nxt_pos;

  assign ph_last = (stride == '0) ? '0 : stride - 1'b1;
  assign at_last = (pos >= last);
  assign nxt_pos = at_last ? '0 : pos + 1'b1;
  assign aligned = (pos >= off) && (phase == '0);

  // phase tracks (pos - off) mod stride once pos has reached off
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos   <= '0;
      phase <= '0;
    end else if (advance) begin
      pos <= nxt_pos;
      if (nxt_pos == off)
        phase <= '0;
      else if (phase >= ph_last)
        phase <= '0;
      else
        phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/pool_word_delay.sv
module pool_word_delay
  import pool_border_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  lane_t lane_in,
  output lane_t lane_tap
);

  localparam int STAGES = DW - 1;

  lane_t stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= '0;
    end else begin
      stage[0] <= lane_in;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign lane_tap = stage[STAGES-1];

endmodule

// File: rtl/pool_border_judge.sv
module pool_border_judge
  import pool_border_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          started,
  input  logic          col_ok,
  input  logic          row_ok,
  input  logic [CW-1:0] col_pos,
  input  logic [CW-1:0] row_pos,
  input  logic [CW-1:0] edge_lim,
  input  logic [1:0]    mode,
  output logic          keep,
  output logic          zero
);

  logic overhang;
  logic pad_mode;

  assign overhang = (col_pos < edge_lim) || (row_pos < edge_lim);
  assign pad_mode = (mode == BM_ZERO_PAD) || (mode == BM_ZERO_PAD2);
  assign keep     = started && col_ok && row_ok;
  assign zero     = keep && pad_mode && overhang;

endmodule

// File: rtl/pool_border_ctrl.sv
module pool_border_ctrl
  import pool_border_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  input  logic [SW-1:0] cfg_stride,
  input  logic [SW-1:0] cfg_win,
  input  logic [1:0]    cfg_mode,
  input  logic          in_bit,
  input  logic          in_first,
  input  logic          in_frame,
  output logic          out_bit,
  output logic          out_first,
  output logic          out_valid
);

  localparam int BW = $clog2(DW + 1);

  logic [BW-1:0] bit_left;
  logic          in_act;
  logic          started;
  logic          restart;
  logic          col_adv;
  logic          row_adv;
  logic [CW-1:0] edge_lim;
  logic [CW-1:0] grid_off;
  logic [CW-1:0] col_last;
  logic [CW-1:0] row_last;
  logic [CW-1:0] col_pos;
  logic [CW-1:0] row_pos;
  logic          col_wrap;
  logic          row_wrap;
  logic          col_ok;
  logic          row_ok;
  logic          j_keep;
  logic          j_zero;
  logic          keep_q;
  logic          zero_q;
  logic          cur_keep;
  logic          cur_zero;
  lane_t         lane_in;
  lane_t         lane_tap;

  // Input word framing
  always_ff @(posedge clk) begin
    if (rst)
      bit_left <= '0;
    else if (in_first)
      bit_left <= BW'(DW - 1);
    else if (bit_left != '0)
      bit_left <= bit_left - 1'b1;
  end

  assign in_act = in_first || (bit_left != '0);

  always_ff @(posedge clk) begin
    if (rst)
      started <= 1'b0;
    else if (in_first && in_frame)
      started <= 1'b1;
  end

  // Coordinate tracking
  assign restart  = in_first && in_frame;
  assign col_adv  = in_first && !in_frame;
  assign row_adv  = col_adv && col_wrap;
  assign col_last = cfg_width - 1'b1;
  assign row_last = cfg_height - 1'b1;
  assign edge_lim = (cfg_win == '0) ? '0 : CW'(cfg_win) - 1'b1;
  assign grid_off = (cfg_mode == BM_EDGE_EXCL) ? edge_lim : '0;

  pool_axis_tracker #(.CW(CW), .SW(SW)) u_col (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .advance (col_adv),
    .last    (col_last),
    .off     (grid_off),
    .stride  (cfg_stride),
    .pos     (col_pos),
    .at_last (col_wrap),
    .aligned (col_ok)
  );

  pool_axis_tracker #(.CW(CW), .SW(SW)) u_row (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .advance (row_adv),
    .last    (row_last),
    .off     (grid_off),
    .stride  (cfg_stride),
    .pos     (row_pos),
    .at_last (row_wrap),
    .aligned (row_ok)
  );

  pool_border_judge #(.CW(CW)) u_judge (
    .started  (started),
    .col_ok   (col_ok),
    .row_ok   (row_ok),
    .col_pos  (col_pos),
    .row_pos  (row_pos),
    .edge_lim (edge_lim),
    .mode     (cfg_mode),
    .keep     (j_keep),
    .zero     (j_zero)
  );

  // One-word alignment of the serial data
  assign lane_in = '{act: in_act, first: in_first, dat: in_bit};

  pool_word_delay #(.DW(DW)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .lane_in  (lane_in),
    .lane_tap (lane_tap)
  );

  // The decision is taken when bit 0 reaches the tap; counters still hold this word then
  assign cur_keep = lane_tap.first ? j_keep : keep_q;
  assign cur_zero = lane_tap.first ? j_zero : zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q    <= 1'b0;
      zero_q    <= 1'b0;
      out_bit   <= 1'b0;
      out_first <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (lane_tap.first) begin
        keep_q <= j_keep;
        zero_q <= j_zero;
      end
      out_first <= lane_tap.first;
      out_valid <= lane_tap.act && cur_keep;
      out_bit   <= lane_tap.dat && !cur_zero;
    end
  end

endmodule

// File: rtl/pool_border_checker.sv
module pool_border_checker #(
  parameter int DW = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       in_bit,
  input logic       in_first,
  input logic       in_frame,
  input logic [1:0] cfg_mode,
  input logic       out_bit,
  input logic       out_first,
  input logic       out_valid
);

  logic [DW-1:0] dly_bit;
  logic [DW-1:0] dly_first;
  logic          seen_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_bit    <= '0;
      dly_first  <= '0;
      seen_frame <= 1'b0;
    end else begin
      dly_bit    <= {dly_bit[DW-2:0], in_bit};
      dly_first  <= {dly_first[DW-2:0], in_first};
      if (in_first && in_frame) seen_frame <= 1'b1;
    end
  end

  AST_NO_VALID_BEFORE_FRAME: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen_frame); // R1

  AST_FIRST_ONE_WORD_LATE: assert property (@(posedge clk) disable iff (rst)
    out_first == dly_first[DW-1]); // R8

  AST_VALID_STEADY_IN_WORD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> $past(out_valid)); // R8

  AST_PASS_DATA_NO_PAD: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode[1] |-> (out_bit == dly_bit[DW-1])); // R6

  AST_ONLY_ZEROING: assert property (@(posedge clk) disable iff (rst)
    out_bit |-> dly_bit[DW-1]); // R7

endmodule

bind pool_border_ctrl pool_border_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_bit    (in_bit),
  .in_first  (in_first),
  .in_frame  (in_frame),
  .cfg_mode  (cfg_mode),
  .out_bit   (out_bit),
  .out_first (out_first),
  .out_valid (out_valid)
);

// File: tb/pool_border_ctrl_bench.sv
`timescale 1ns/1ps
module pool_border_ctrl_bench;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cfg_width  = '0;
  logic [CW-1:0] cfg_height = '0;
  logic [SW-1:0] cfg_stride = '0;
  logic [SW-1:0] cfg_win    = '0;
  logic [1:0]    cfg_mode   = '0;
  logic          in_bit = 1'b0, in_first = 1'b0, in_frame = 1'b0;
  logic          out_bit, out_first, out_valid;

  always #2 clk = ~clk;

  pool_border_ctrl #(.DW(DW), .CW(CW), .SW(SW)) u_pool_border_ctrl (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_stride(cfg_stride), .cfg_win(cfg_win), .cfg_mode(cfg_mode),
    .in_bit(in_bit), .in_first(in_first), .in_frame(in_frame),
    .out_bit(out_bit), .out_first(out_first), .out_valid(out_valid)
  );

  int checks = 0, errors = 0, stray = 0;
  bit done = 0;

  bit            q_v[$];
  logic [DW-1:0] q_d[$];
  string         q_t[$];

  int bc = 0, br = 0, mw = 1, mh = 1, ms = 1, mk = 1, mm = 0;
  bit bstart = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_bit = 1'b0; in_first = 1'b0; in_frame = 1'b0;
    end
  endtask

  task automatic set_cfg(input int w, input int h, input int s, input int k, input int m);
    idle(DW + 3);
    mw = w; mh = h; ms = s; mk = k; mm = m;
    cfg_width = CW'(w); cfg_height = CW'(h);
    cfg_stride = SW'(s); cfg_win = SW'(k); cfg_mode = 2'(m);
  endtask

  // Driver: model position, push expectation, drive the word serially
  task automatic send_word(input logic [DW-1:0] val, input bit frm, input int gap,
                           input string tag);
    bit keep, zero;
    int k1;
    if (frm) begin
      bc = 0; br = 0; bstart = 1;
    end else if (bc == mw - 1) begin
      bc = 0; br = (br == mh - 1) ? 0 : br + 1;
    end else begin
      bc = bc + 1;
    end
    k1 = mk - 1;
    if (!bstart) keep = 0;
    else if (mm == 0)
      keep = (br >= k1) && (bc >= k1) && ((br - k1) % ms == 0) && ((bc - k1) % ms == 0);
    else
      keep = (br % ms == 0) && (bc % ms == 0);
    zero = keep && (mm >= 2) && ((br < k1) || (bc < k1));
    q_v.push_back(keep);
    q_d.push_back(zero ? '0 : val);
    q_t.push_back(keep ? (zero ? {tag, " R7"} : tag) : {tag, " R9"});
    for (int i = 0; i < DW; i++) begin
      @(negedge clk);
      in_first = (i == 0);
      in_frame = (i == 0) && frm;
      in_bit   = val[i];
    end
    if (gap > 0) idle(gap);
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int s);
    return DW'((i * 37 + s * 11 + 91) | 1);
  endfunction

  // Monitor: collect each output word and compare with the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (out_first) begin
          logic [DW-1:0] got;
          bit vseen, vok, ev;
          logic [DW-1:0] ed;
          string et;
          got = '0;
          got[0] = out_bit;
          vseen = out_valid;
          vok = 1;
          for (int i = 1; i < DW; i++) begin
            @(negedge clk);
            got[i] = out_bit;
            if (out_valid != vseen || out_first) vok = 0;
          end
          if (q_v.size() == 0) begin
            check(0, "R8", "unexpected word", int'(got), 0);
          end else begin
            ev = q_v.pop_front(); ed = q_d.pop_front(); et = q_t.pop_front();
            check(vok, {et, " R8"}, "valid not steady over word", int'(vseen), int'(ev));
            check(vseen == ev, et, "valid", int'(vseen), int'(ev));
            check(got == ed, et, "data", int'(got), int'(ed));
          end
        end else if (out_valid) begin
          stray++;
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    set_cfg(4, 3, 1, 1, 1);
    rst = 1'b1;
    idle(5);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid && !out_first && !out_bit, "R1", "reset outputs",
            {out_valid, out_first, out_bit}, 0);
    end

    // R1: words before any frame start are invalid
    for (int i = 0; i < 3; i++) send_word(pat(i, 1), 0, 0, "R1");

    // R5 edge-exclusive, stride 2, window 2, back to back
    set_cfg(6, 5, 2, 2, 0);
    for (int i = 0; i < 30; i++) send_word(pat(i, 2), i == 0, 0, "R4 R5");

    // R6 edge-inclusive, window 3, stride 2, gaps between words
    set_cfg(5, 4, 2, 3, 1);
    for (int i = 0; i < 20; i++) send_word(pat(i, 3), i == 0, 3, "R4 R6");

    // R7 zero-padding, window 3, stride 1
    set_cfg(4, 4, 1, 3, 2);
    for (int i = 0; i < 16; i++) send_word(pat(i, 4), i == 0, 0, "R7");

    // R7 mode 3, stride 3, window 2
    set_cfg(7, 3, 3, 2, 3);
    for (int i = 0; i < 21; i++) send_word(pat(i, 5), i == 0, 1, "R4 R7");

    // R2: stream runs past the frame end and wraps to row 0
    set_cfg(3, 2, 2, 1, 1);
    for (int i = 0; i < 12; i++) send_word(pat(i, 6), i == 0, 0, "R2");

    // R3: frame restart mid-row
    set_cfg(4, 4, 2, 2, 0);
    for (int i = 0; i < 5; i++) send_word(pat(i, 7), i == 0, 0, "R3");
    for (int i = 0; i < 16; i++) send_word(pat(i, 8), i == 0, 0, "R3");

    idle(DW + 4);
    check(q_v.size() == 0, "R8", "words not emitted", q_v.size(), 0);
    check(stray == 0, "R8", "valid outside a word", stray, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule